// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block decides whether a 64-bit candidate password may open protected storage. It keeps two independent secrets, one guarding reads and one guarding writes. Candidate bytes arrive one per strobe, most significant byte first. A check strobe then compares the collected word against the secret chosen by a select input. Every check starts a self-timed busy interval, whether the password was right or wrong, so that guessing stays slow. A poll strobe reports back only when the password matched and that interval has ended.

Consecutive failures are counted. When the limit is reached, the block pulses one strobe that tells the storage array to erase itself and another that reports that both secrets have been zeroed. A session that was opened with the write secret may replace either secret with a fresh 8-byte value. That replacement also runs a busy interval. The serial bit layer and the storage array sit outside this block.

Top module: `pw_guard`

## Requirements
- R1: After reset, `granted`, `busy`, `poll_ack`, `wipe_array` and `wipe_pwd` are 0, and both secrets equal 64'h0.
- R2: A `check_go` taken while idle compares the last 8 bytes received, first byte in bits 63:56, against the secret picked by `sel_write` (0 = read secret, 1 = write secret). A match sets `granted` and clears the failure count. A mismatch clears `granted`.
- R3: A check counts as a failure when fewer or more than exactly 8 bytes arrived since the previous check or change request, even if the last 8 bytes would match.
- R4: Every accepted check or password change makes `busy` high from the next cycle for exactly BUSY_CYCLES cycles.
- R5: `poll_ack` is high in the cycle after `poll_go` exactly when `granted` was 1 and `busy` was 0 in the cycle of `poll_go`. A wrong password therefore gets no acknowledge, even after the busy interval.
- R6: The MAX_FAILS-th consecutive failed check (default 8) pulses `wipe_array` and `wipe_pwd` together for one cycle, zeroes both secrets, clears `granted` and resets the failure count. A successful check before that point restarts the count.
- R7: `chg_go` while idle, with `granted` obtained through the write secret and exactly 8 new bytes received, stores those bytes into the secret picked by `sel_write` and starts a busy interval. Without a write-secret grant, the request is ignored: no busy interval starts and both secrets are unchanged.
- R8: While `busy` is high, `byte_valid`, `check_go` and `chg_go` are ignored.
- R9: The read secret does not match a check made against the write secret, and the write secret does not match a check made against the read secret.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_valid | input | 1 | One candidate or new-secret byte is present |
| byte_data | input | 8 | Byte value, most significant byte of the word first |
| sel_write | input | 1 | 0 selects the read secret, 1 selects the write secret |
| check_go | input | 1 | Compare the collected bytes against the selected secret |
| poll_go | input | 1 | Ask whether access is open and the busy interval is over |
| chg_go | input | 1 | Replace the selected secret with the collected bytes |
| granted | output | 1 | Access open since the last successful check |
| busy | output | 1 | Self-timed busy interval running |
| poll_ack | output | 1 | Acknowledge of the previous cycle's poll |
| wipe_array | output | 1 | One-cycle strobe: erase the storage array |
| wipe_pwd | output | 1 | One-cycle strobe: both secrets were zeroed |

## Verification
A poll can land in the same cycle in which the busy countdown ends. The bench issues a poll exactly BUSY_CYCLES cycles after a correct check. It expects no acknowledge and `busy` already low, and the poll in the next cycle must be acknowledged. In the same way, a fresh check and a new set of bytes are sent while the lockout interval is still running. The bench then confirms through `granted` and a later check that neither had any effect.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;
endpackage

// File: rtl/pwg_accum.sv
module pwg_accum #(
  parameter int unsigned NBYTES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic                             clr,
  input  logic [pwg_pkg::BYTE_W-1:0]       din,
  output logic [NBYTES*pwg_pkg::BYTE_W-1:0] word,
  output logic                             full
);
  localparam int unsigned WW = NBYTES * pwg_pkg::BYTE_W;
  localparam int unsigned CW = $clog2(NBYTES + 2);
  localparam logic [CW-1:0] CNT_EXACT = CW'(NBYTES);
  localparam logic [CW-1:0] CNT_OVER  = CW'(NBYTES + 1);

  logic [WW-1:0] word_q, word_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      word_d = {word_q[WW-pwg_pkg::BYTE_W-1:0], din};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr || en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word = word_q;
  assign full = (cnt_q == CNT_EXACT);
endmodule

// File: rtl/pwg_busy_timer.sv
module pwg_busy_timer #(
  parameter int unsigned CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned TW = $clog2(CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(CYCLES);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pwg_vault.sv
module pwg_vault #(
  parameter int unsigned WW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [WW-1:0] wr_data,
  input  logic          cmp_sel,
  input  logic [WW-1:0] cmp_data,
  output logic          match,
  output logic          wiped
);
  localparam int unsigned NSLOT = 2;

  logic [WW-1:0] pw_q [NSLOT];
  logic          wiped_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [WW-1:0] pw_d;
    logic          upd;

    always_comb begin
      upd  = wipe || (wr_en && (wr_sel == g[0]));
      pw_d = wipe ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pw_q[g] <= '0;
      else if (upd) pw_q[g] <= pw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiped_q <= 1'b0;
    else        wiped_q <= wipe;
  end

  assign match = (cmp_data == pw_q[cmp_sel]);
  assign wiped = wiped_q;
endmodule

// File: rtl/pw_guard.sv
module pw_guard #(
  parameter int unsigned PW_BYTES    = 8,
  parameter int unsigned BUSY_CYCLES = 12,
  parameter int unsigned MAX_FAILS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       sel_write,
  input  logic       check_go,
  input  logic       poll_go,
  input  logic       chg_go,
  output logic       granted,
  output logic       busy,
  output logic       poll_ack,
  output logic       wipe_array,
  output logic       wipe_pwd
);
  import pwg_pkg::*;

  localparam int unsigned WW  = PW_BYTES * BYTE_W;
  localparam int unsigned FCW = (MAX_FAILS > 1) ? $clog2(MAX_FAILS) : 1;
  localparam logic [FCW-1:0] FAIL_LAST = FCW'(MAX_FAILS - 1);

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [WW-1:0] cand;
  logic          cand_full, pw_match, accept;
  logic          do_check, do_change, good, bad, lockout;
  slot_e         sel;

  assign sel       = slot_e'(sel_write);
  assign accept    = !busy;
  assign do_check  = check_go && accept;
  assign good      = do_check && cand_full && pw_match;
  assign bad       = do_check && !good;

  logic [FCW-1:0] fails_q, fails_d;
  logic           grant_q, grant_d;
  slot_e          gslot_q, gslot_d;
  logic           ack_q, ack_d;
  logic           wipe_q;

  assign lockout   = bad && (fails_q == FAIL_LAST);
  assign do_change = chg_go && accept && grant_q && (gslot_q == SLOT_WR) && cand_full;

  pwg_accum #(.NBYTES(PW_BYTES)) u_accum (
    .clk  (clk),
    .rst_n(rst_q),
    .en   (byte_valid && accept),
    .clr  ((check_go || chg_go) && accept),
    .din  (byte_data),
    .word (cand),
    .full (cand_full)
  );

  pwg_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_q),
    .start(do_check || do_change),
    .busy (busy)
  );

  pwg_vault #(.WW(WW)) u_vault (
    .clk     (clk),
    .rst_n   (rst_q),
    .wipe    (lockout),
    .wr_en   (do_change),
    .wr_sel  (sel_write),
    .wr_data (cand),
    .cmp_sel (sel_write),
    .cmp_data(cand),
    .match   (pw_match),
    .wiped   (wipe_pwd)
  );

  always_comb begin
    fails_d = fails_q;
    grant_d = grant_q;
    gslot_d = gslot_q;
    if (good) begin
      fails_d = '0;
      grant_d = 1'b1;
      gslot_d = sel;
    end else if (bad) begin
      grant_d = 1'b0;
      fails_d = lockout ? '0 : fails_q + 1'b1;
    end
    ack_d = poll_go && grant_q && !busy;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fails_q <= '0;
      grant_q <= 1'b0;
      gslot_q <= SLOT_RD;
      ack_q   <= 1'b0;
      wipe_q  <= 1'b0;
    end else begin
      if (do_check) begin
        fails_q <= fails_d;
        grant_q <= grant_d;
        gslot_q <= gslot_d;
      end
      ack_q  <= ack_d;
      wipe_q <= lockout;
    end
  end

  assign granted    = grant_q;
  assign poll_ack   = ack_q;
  assign wipe_array = wipe_q;
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker (
  input logic clk,
  input logic rst_n,
  input logic check_go,
  input logic poll_go,
  input logic busy,
  input logic granted,
  input logic poll_ack,
  input logic wipe_array,
  input logic wipe_pwd
);
  p_grant_from_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(check_go) && !$past(busy));

  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (check_go && !busy) |=> busy);

  p_poll_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> $past(poll_go) && $past(granted) && !$past(busy));

  p_wipe_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_array |-> wipe_pwd && busy && !granted);

  p_wipe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_array |=> !wipe_array);

  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(granted));
endmodule

bind pw_guard pwg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .check_go  (check_go),
  .poll_go   (poll_go),
  .busy      (busy),
  .granted   (granted),
  .poll_ack  (poll_ack),
  .wipe_array(wipe_array),
  .wipe_pwd  (wipe_pwd)
);

// File: tb/tb_pw_guard.sv
`timescale 1ns/1ps
module tb_pw_guard;
  localparam int BUSY = 12;
  localparam int FAILS = 8;
  localparam logic [63:0] WPW = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] RPW = 64'hFEDC_BA98_7654_3210;

  logic clk = 1'b0;
  logic rst_n, byte_valid, sel_write, check_go, poll_go, chg_go;
  logic [7:0] byte_data;
  logic granted, busy, poll_ack, wipe_array, wipe_pwd;
  int   n_checks = 0, n_fail = 0;
  bit   finished = 0;

  always #2 clk = ~clk;

  pw_guard #(.PW_BYTES(8), .BUSY_CYCLES(BUSY), .MAX_FAILS(FAILS)) dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .sel_write(sel_write), .check_go(check_go), .poll_go(poll_go), .chg_go(chg_go),
    .granted(granted), .busy(busy), .poll_ack(poll_ack),
    .wipe_array(wipe_array), .wipe_pwd(wipe_pwd));

  task automatic expect_eq(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bytes(logic [63:0] w, int n);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      byte_data  = w[63 - 8*i -: 8];
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  task automatic do_check(logic s);
    sel_write = s; check_go = 1'b1;
    @(negedge clk);
    check_go = 1'b0;
  endtask

  task automatic do_change(logic s);
    sel_write = s; chg_go = 1'b1;
    @(negedge clk);
    chg_go = 1'b0;
  endtask

  task automatic do_poll(output logic ack);
    poll_go = 1'b1;
    @(negedge clk);
    poll_go = 1'b0;
    ack = poll_ack;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic login(string tag, logic [63:0] w, logic s, logic exp_grant);
    send_bytes(w, 8);
    do_check(s);
    expect_eq(tag, granted, exp_grant);
    wait_idle();
  endtask

  task automatic t_reset();
    expect_eq("R1 reset outputs", {granted, busy, poll_ack, wipe_array, wipe_pwd}, 5'b0);
  endtask

  task automatic t_default_and_poll_edge();
    logic ack;
    send_bytes(64'h0, 8);
    do_check(1'b0);
    expect_eq("R1 zero read secret grants", granted, 1);
    expect_eq("R4 busy after check", busy, 1);
    repeat (BUSY - 1) @(negedge clk);
    expect_eq("R4 busy still high at last cycle", busy, 1);
    do_poll(ack);
    expect_eq("R5 poll on final busy cycle nack", ack, 0);
    expect_eq("R4 busy low after BUSY cycles", busy, 0);
    do_poll(ack);
    expect_eq("R5 poll after busy acks", ack, 1);
  endtask

  task automatic t_change();
    logic ack;
    send_bytes(WPW, 8);
    do_change(1'b1);
    expect_eq("R7 change under read grant ignored", busy, 0);
    login("R1 zero write secret grants", 64'h0, 1'b1, 1);
    send_bytes(WPW, 8);
    do_change(1'b1);
    expect_eq("R7 change starts busy", busy, 1);
    wait_idle();
    send_bytes(RPW, 8);
    do_change(1'b0);
    expect_eq("R7 second change starts busy", busy, 1);
    wait_idle();
    do_poll(ack);
    expect_eq("R7 poll after change acks", ack, 1);
    login("R7 new write secret grants", WPW, 1'b1, 1);
    login("R7 new read secret grants", RPW, 1'b0, 1);
    login("R7 old zero read secret rejected", 64'h0, 1'b0, 0);
  endtask

  task automatic t_independent_and_counts();
    logic ack;
    login("R9 read secret as write rejected", RPW, 1'b1, 0);
    do_poll(ack);
    expect_eq("R5 wrong password nack after busy", ack, 0);
    login("R9 write secret as read rejected", WPW, 1'b0, 0);
    send_bytes(WPW, 7);
    do_check(1'b1);
    expect_eq("R3 seven bytes fail", granted, 0);
    wait_idle();
    byte_valid = 1'b1; byte_data = 8'h5A; @(negedge clk); byte_valid = 1'b0;
    send_bytes(WPW, 8);
    do_check(1'b1);
    expect_eq("R3 nine bytes fail", granted, 0);
    wait_idle();
    login("R2 byte order reversed fails", {<<8{WPW}}, 1'b1, 0);
    login("R2 correct write secret resets count", WPW, 1'b1, 1);
  endtask

  task automatic t_lockout();
    logic ack;
    for (int i = 0; i < FAILS - 1; i++) begin
      send_bytes(64'hDEAD_BEEF_0000_0000 + 64'(i), 8);
      do_check(1'b1);
      expect_eq("R6 no wipe before limit", {wipe_array, wipe_pwd}, 2'b00);
      wait_idle();
    end
    send_bytes(64'hBAD0, 8);
    do_check(1'b0);
    expect_eq("R6 wipe strobes at limit", {wipe_array, wipe_pwd, granted}, 3'b110);
    // still inside the lockout busy interval: try bytes and a check
    send_bytes(64'h0, 8);
    do_check(1'b0);
    expect_eq("R6 wipe is a single pulse", {wipe_array, wipe_pwd}, 2'b00);
    expect_eq("R8 check during busy ignored", granted, 0);
    wait_idle();
    do_check(1'b0);
    expect_eq("R8 bytes during busy ignored", granted, 0);
    wait_idle();
    do_poll(ack);
    expect_eq("R5 nack after failed check", ack, 0);
    login("R6 read secret zeroed", 64'h0, 1'b0, 1);
    login("R6 write secret zeroed", 64'h0, 1'b1, 1);
  endtask

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0; sel_write = 1'b0;
    check_go = 1'b0; poll_go = 1'b0; chg_go = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_default_and_poll_edge();
    t_change();
    t_independent_and_counts();
    t_lockout();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule